// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits on the memory side of a shared word-addressed store and gives several requesters optimistic synchronization without ever holding the bus. Any requester may read or write plainly. It may also issue a load-exclusive, which returns the word and records a reservation for that requester on that word. A later store-exclusive from the same requester succeeds only if that reservation is still intact. On success it writes the word and reports status 0. Otherwise it writes nothing and reports status 1.

Each requester owns one reservation entry, made of a valid bit and a word index. A committed write to a word, whether a plain write or a successful store-exclusive, cancels every other requester's reservation on that word. Every request completes in a single accepted cycle, so no requester waits on another's reservation.

Requests pass through a fixed-priority grant: at most one is accepted per cycle, and the lowest index wins. A small internal memory model holds the data. The response appears one cycle after acceptance, on a single response bus tagged with the requester index.

Top module: `excl_mon`

## Requirements
- R1: After reset every memory word reads 0, no requester holds a reservation, `rsp_valid` is low and no grant is given without a request.
- R2: In any cycle at most one `req_gnt` bit is high, combinationally. It is the lowest-indexed requester whose `req_valid` is high, and a requester with a pending request is accepted on the clock edge where its grant is high.
- R3: A request accepted on an edge produces exactly one response: `rsp_valid` is high for the cycle after that edge, with `rsp_id` equal to the accepted requester's index. There is no response in a cycle that follows an edge with no acceptance.
- R4: The operation encoding is 2'b00 read, 2'b01 write, 2'b10 load-exclusive and 2'b11 store-exclusive. A read returns the addressed word with `rsp_fail` 0. A plain write stores the data and returns `rsp_rdata` 0 with `rsp_fail` 0.
- R5: A load-exclusive returns the addressed word with `rsp_fail` 0 and sets the requester's reservation to that word index. This replaces any earlier reservation the requester held.
- R6: A store-exclusive succeeds only when the requester's reservation is valid and names the same word. On success it writes the data and returns `rsp_fail` 0. Otherwise it returns `rsp_fail` 1 and memory is left unchanged. Both cases return `rsp_rdata` 0.
- R7: A store-exclusive always clears the issuing requester's reservation, whether it succeeds or fails.
- R8: A committed write to a word clears the reservations that other requesters hold on that word. It leaves the writer's own reservation and reservations on other words intact.
- R9: When two requesters present store-exclusives to the same reserved word in the same cycle, only the lower-indexed one succeeds and the other reports failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Per-requester request present |
| req_op | input | 2*N | Per-requester operation code, requester i in bits [2i+1:2i] |
| req_addr | input | N*AW | Per-requester word index |
| req_wdata | input | N*DW | Per-requester write data |
| req_gnt | output | N | Combinational grant, one-hot or zero |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | IW | Index of the requester being answered |
| rsp_rdata | output | DW | Read data for read and load-exclusive, else 0 |
| rsp_fail | output | 1 | Store-exclusive status: 0 success, 1 failure |

## Verification
The bound checker watches the grant on every cycle: it is one-hot or zero, follows priority and never lands on an idle requester. It also checks that every acceptance yields one tagged response on the next cycle, that only store-exclusives can report failure, and that a load-exclusive arms and a store-exclusive disarms the issuer's reservation. Whether a store-exclusive should succeed depends on the history of other requesters' writes, so only the bench scenarios show that. They cover cancellation by a foreign write, the writer keeping its own reservation, address mismatch, replaced reservations and two same-cycle store-exclusives. The bench confirms that a failed store left memory untouched by reading the word back.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    typedef enum logic [1:0] {
        OP_RD  = 2'b00,
        OP_WR  = 2'b01,
        OP_LDX = 2'b10,
        OP_STX = 2'b11
    } op_e;

endpackage

// File: rtl/excl_mon_arb.sv
module excl_mon_arb #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Lowest index wins: scan from the top so the last hit is the lowest.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/excl_mon_resv.sv
module excl_mon_resv
    import excl_mon_pkg::*;
#(
    parameter  int N     = 4,
    parameter  int DEPTH = 16,
    localparam int IW    = (N > 1) ? $clog2(N) : 1,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic [IW-1:0] acc_id,
    input  op_e           acc_op,
    input  logic [AW-1:0] acc_word,
    output logic          stx_ok,
    output logic          wr_commit,
    output logic [N-1:0]  resv_vld
);

    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][AW-1:0] word;
    } resv_t;

    resv_t st_d, st_q;
    logic  own_hit;

    always_comb begin
        st_d    = st_q;
        own_hit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (IW'(i) == acc_id && st_q.vld[i] && st_q.word[i] == acc_word) begin
                own_hit = 1'b1;
            end
        end
        stx_ok    = acc_en && (acc_op == OP_STX) && own_hit;
        wr_commit = acc_en && ((acc_op == OP_WR) || stx_ok);

        for (int i = 0; i < N; i++) begin
            // Foreign committed write cancels matching reservations.
            if (wr_commit && IW'(i) != acc_id &&
                st_q.vld[i] && st_q.word[i] == acc_word) begin
                st_d.vld[i] = 1'b0;
            end
            if (acc_en && IW'(i) == acc_id) begin
                if (acc_op == OP_LDX) begin
                    st_d.vld[i]  = 1'b1;
                    st_d.word[i] = acc_word;
                end else if (acc_op == OP_STX) begin
                    st_d.vld[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resv_vld = st_q.vld;

endmodule

// File: rtl/excl_mon_mem.sv
module excl_mon_mem #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    typedef logic [DEPTH-1:0][DW-1:0] words_t;

    words_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[addr] = wdata;
        end
        rdata = mem_q[addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/excl_mon.sv
module excl_mon
    import excl_mon_pkg::*;
#(
    parameter  int N     = 4,
    parameter  int DEPTH = 16,
    parameter  int DW    = 32,
    localparam int IW    = (N > 1) ? $clog2(N) : 1,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    input  logic [2*N-1:0]  req_op,
    input  logic [N*AW-1:0] req_addr,
    input  logic [N*DW-1:0] req_wdata,
    output logic [N-1:0]    req_gnt,
    output logic            rsp_valid,
    output logic [IW-1:0]   rsp_id,
    output logic [DW-1:0]   rsp_rdata,
    output logic            rsp_fail
);

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] id;
        logic [DW-1:0] rdata;
        logic          fail;
    } rsp_t;

    logic          any_w;
    logic [IW-1:0] idx_w;
    op_e           sel_op;
    logic [AW-1:0] sel_word;
    logic [DW-1:0] sel_data;
    logic          stx_ok;
    logic          wr_commit;
    logic [N-1:0]  resv_vld;
    logic [DW-1:0] mem_rdata;
    rsp_t          rsp_d, rsp_q;

    excl_mon_arb #(.N(N)) u_arb (
        .req (req_valid),
        .gnt (req_gnt),
        .any (any_w),
        .idx (idx_w)
    );

    // Route the granted requester's fields to the shared datapath.
    always_comb begin
        sel_op   = OP_RD;
        sel_word = '0;
        sel_data = '0;
        for (int i = 0; i < N; i++) begin
            if (req_gnt[i]) begin
                sel_op   = op_e'(req_op[2*i +: 2]);
                sel_word = req_addr[AW*i +: AW];
                sel_data = req_wdata[DW*i +: DW];
            end
        end
    end

    excl_mon_resv #(.N(N), .DEPTH(DEPTH)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (any_w),
        .acc_id    (idx_w),
        .acc_op    (sel_op),
        .acc_word  (sel_word),
        .stx_ok    (stx_ok),
        .wr_commit (wr_commit),
        .resv_vld  (resv_vld)
    );

    excl_mon_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_commit),
        .addr  (sel_word),
        .wdata (sel_data),
        .rdata (mem_rdata)
    );

    always_comb begin
        rsp_d = '0;
        if (any_w) begin
            rsp_d.vld = 1'b1;
            rsp_d.id  = idx_w;
            if (sel_op == OP_RD || sel_op == OP_LDX) begin
                rsp_d.rdata = mem_rdata;
            end
            rsp_d.fail = (sel_op == OP_STX) && !stx_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_id    = rsp_q.id;
    assign rsp_rdata = rsp_q.rdata;
    assign rsp_fail  = rsp_q.fail;

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk
    import excl_mon_pkg::*;
#(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   req_valid,
    input logic [2*N-1:0] req_op,
    input logic [N-1:0]   req_gnt,
    input logic           rsp_valid,
    input logic [IW-1:0]  rsp_id,
    input logic           rsp_fail,
    input logic [N-1:0]   resv_vld
);

    logic [IW-1:0] g_idx;
    op_e           g_op;
    logic          g_any;

    always_comb begin
        g_idx = '0;
        g_op  = OP_RD;
        for (int i = 0; i < N; i++) begin
            if (req_gnt[i]) begin
                g_idx = IW'(i);
                g_op  = op_e'(req_op[2*i +: 2]);
            end
        end
        g_any = |req_gnt;
    end

    a_r2_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_gnt));

    a_r2_gnt_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid != '0) |-> (req_gnt != '0) &&
                              (((req_gnt - 1'b1) & req_valid) == '0));

    a_r1_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_gnt & ~req_valid) == '0);

    a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        g_any |=> rsp_valid && (rsp_id == $past(g_idx)));

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !g_any |=> !rsp_valid);

    a_r4_plain_no_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (g_any && g_op != OP_STX) |=> !rsp_fail);

    a_r5_ldx_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (g_any && g_op == OP_LDX) |=> resv_vld[$past(g_idx)]);

    a_r7_stx_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (g_any && g_op == OP_STX) |=> !resv_vld[$past(g_idx)]);

endmodule

bind excl_mon excl_mon_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_gnt   (req_gnt),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .rsp_fail  (rsp_fail),
    .resv_vld  (resv_vld)
);

// File: tb/excl_mon_bench.sv
module excl_mon_bench;

    localparam int N     = 4;
    localparam int DEPTH = 16;
    localparam int DW    = 32;
    localparam int IW    = 2;
    localparam int AW    = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [2*N-1:0]  req_op = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0]    req_gnt;
    logic            rsp_valid;
    logic [IW-1:0]   rsp_id;
    logic [DW-1:0]   rsp_rdata;
    logic            rsp_fail;

    always #5 clk = ~clk;

    excl_mon #(.N(N), .DEPTH(DEPTH), .DW(DW)) u_excl_mon (.*);

    typedef struct {
        int          id;
        logic [31:0] rdata;
        logic        fail;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] mem_m [DEPTH];
    logic        rv_m  [N];
    int          ra_m  [N];
    logic [1:0]  op_b  [N];
    int          ad_b  [N];
    logic [31:0] dt_b  [N];

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference behaviour taken from the requirements.
    task automatic model(input int i, input string tag);
        exp_t e;
        logic ok;
        e.id = i; e.rdata = '0; e.fail = 1'b0; e.tag = tag;
        case (op_b[i])
            2'b00: e.rdata = mem_m[ad_b[i]];
            2'b01: begin
                mem_m[ad_b[i]] = dt_b[i];
                for (int k = 0; k < N; k++)
                    if (k != i && ra_m[k] == ad_b[i]) rv_m[k] = 1'b0;
            end
            2'b10: begin
                e.rdata = mem_m[ad_b[i]];
                rv_m[i] = 1'b1; ra_m[i] = ad_b[i];
            end
            default: begin
                ok = rv_m[i] && ra_m[i] == ad_b[i];
                e.fail = !ok;
                rv_m[i] = 1'b0;
                if (ok) begin
                    mem_m[ad_b[i]] = dt_b[i];
                    for (int k = 0; k < N; k++)
                        if (k != i && ra_m[k] == ad_b[i]) rv_m[k] = 1'b0;
                end
            end
        endcase
        sb.push_back(e);
    endtask

    // Driver: present the masked requests until each has been granted.
    task automatic run_batch(input logic [N-1:0] mask, input string tag);
        logic [N-1:0] pend;
        pend = mask;
        while (pend != '0) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                req_valid[i]           = pend[i];
                req_op[2*i +: 2]       = op_b[i];
                req_addr[AW*i +: AW]   = AW'(ad_b[i]);
                req_wdata[DW*i +: DW]  = dt_b[i];
            end
            #1;
            chk(req_gnt == (pend & (~pend + 1'b1)), "R2 grant", req_gnt,
                pend & (~pend + 1'b1));
            for (int i = 0; i < N; i++) begin
                if (req_gnt[i]) begin
                    model(i, tag);
                    pend[i] = 1'b0;
                end
            end
            @(posedge clk);
        end
        @(negedge clk);
        req_valid = '0;
        @(negedge clk);
    endtask

    task automatic one(input int i, input logic [1:0] op, input int a,
                       input logic [31:0] d, input string tag);
        op_b[i] = op; ad_b[i] = a; dt_b[i] = d;
        run_batch(N'(1) << i, tag);
    endtask

    // Monitor: compare every response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3 unexpected response", 64'(rsp_id), 64'hffff);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_id == IW'(e.id), {e.tag, " id"}, 64'(rsp_id), 64'(e.id));
                chk(rsp_rdata == e.rdata, {e.tag, " rdata"}, 64'(rsp_rdata),
                    64'(e.rdata));
                chk(rsp_fail == e.fail, {e.tag, " status"}, 64'(rsp_fail),
                    64'(e.fail));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) mem_m[k] = '0;
        for (int k = 0; k < N; k++) begin
            rv_m[k] = 1'b0; ra_m[k] = -1;
            op_b[k] = '0; ad_b[k] = 0; dt_b[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp idle in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_gnt == '0, "R1 idle after reset",
            64'({rsp_valid, req_gnt}), 64'd0);

        one(2, 2'b00, 5, '0, "R1 memory zero");
        one(0, 2'b11, 5, 32'h5555, "R1 R6 no reservation");
        one(3, 2'b00, 5, '0, "R6 failed store no write");

        one(1, 2'b01, 4, 32'h1111, "R4 write");
        one(2, 2'b00, 4, '0, "R4 read");

        one(0, 2'b10, 4, '0, "R5 load-excl");
        one(0, 2'b11, 4, 32'haaaa, "R6 store-excl ok");
        one(1, 2'b00, 4, '0, "R6 written");
        one(0, 2'b11, 4, 32'hbbbb, "R7 reservation consumed");
        one(1, 2'b00, 4, '0, "R7 no write");

        one(1, 2'b10, 8, '0, "R8 arm");
        one(2, 2'b01, 8, 32'h2222, "R8 foreign write");
        one(1, 2'b11, 8, 32'hdead, "R8 cancelled");
        one(0, 2'b00, 8, '0, "R8 value kept");

        one(3, 2'b10, 9, '0, "R8 own arm");
        one(3, 2'b01, 9, 32'h3333, "R8 own write");
        one(3, 2'b11, 9, 32'h3434, "R8 own keeps");

        one(0, 2'b10, 10, '0, "R8 other word arm");
        one(1, 2'b01, 11, 32'h4444, "R8 other word write");
        one(0, 2'b11, 10, 32'h4545, "R8 other word intact");

        one(1, 2'b10, 2, '0, "R6 arm mismatch");
        one(1, 2'b11, 3, 32'h6666, "R6 address mismatch");
        one(2, 2'b00, 3, '0, "R6 mismatch no write");

        one(3, 2'b10, 1, '0, "R5 first arm");
        one(3, 2'b10, 6, '0, "R5 re-arm");
        one(3, 2'b11, 1, 32'h7777, "R5 old reservation replaced");

        one(0, 2'b10, 15, '0, "R9 arm low");
        one(2, 2'b10, 15, '0, "R9 arm high");
        op_b[0] = 2'b11; ad_b[0] = 15; dt_b[0] = 32'h8888;
        op_b[2] = 2'b11; ad_b[2] = 15; dt_b[2] = 32'h9999;
        run_batch(4'b0101, "R9 same-cycle stores");
        one(1, 2'b00, 15, '0, "R9 winner data");

        for (int k = 0; k < N; k++) begin
            op_b[k] = 2'b00; ad_b[k] = k + 8; dt_b[k] = '0;
        end
        run_batch(4'b1111, "R2 R3 four reads");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R3 all responses seen", 64'(sb.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule